// File: doc/BRIEF.md
# AES Single-Round Encryption Datapath

This block applies one forward AES cipher round to the low 128 bits of a wide vector lane. The low half of the lane is the cipher state. It is rotated by rows, passed byte by byte through the forward substitution box, mixed by columns, and then combined by XOR with a 128-bit round key. The result replaces the low half of the lane. The bits above bit 127 are copied from the incoming lane unchanged. The lane is both the source and the destination, so the output word is meant to be written back over the same register it was read from.

A `last_round` input selects the closing-round form. That form skips the column mixing step and keeps the other steps in the same order. A caller that builds a full cipher issues one request per round, sets `last_round` only on the final request, and generates the round keys elsewhere. Each request is a one-cycle `start` pulse. The registered result appears with `valid_out` on the next cycle. A new request may be issued on every cycle.

Top module: `aes_round_lane`

## Requirements
- R1: With `start`=1 and `last_round`=0, the next-cycle `lane_out[127:0]` equals MixColumns(SubBytes(ShiftRows(`lane_in[127:0]`))) XOR `round_key`. The state byte i sits at bits 8i+7:8i. Column c holds bytes 4c..4c+3, and row r is the byte index r within its column.
- R2: With `start`=1 and `last_round`=1, the next-cycle `lane_out[127:0]` equals SubBytes(ShiftRows(`lane_in[127:0]`)) XOR `round_key`, with no column mixing.
- R3: On the cycle after a start, `lane_out[255:128]` equals the `lane_in[255:128]` that was present at the start.
- R4: `valid_out` is 1 exactly on the cycle after a cycle with `start`=1 (outside reset), and 0 otherwise.
- R5: While `start`=0, `lane_out` keeps its value whatever `lane_in`, `round_key` and `last_round` do.
- R6: A synchronous active-high `rst` clears `lane_out` to zero and `valid_out` to 0 on the next edge, even if `start` is 1.
- R7: Substitution maps each byte to the affine transform of its multiplicative inverse in GF(2^8) modulo 0x11B, with 0 treated as its own inverse. An all-zero byte therefore becomes 0x63, and mixing uses the matrix rows {02,03,01,01} rotated per row.
- R8: Starts on consecutive cycles give a correct result on each following cycle, with any mix of round kinds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to compute a round |
| last_round | input | 1 | 1 selects the closing round without column mixing |
| lane_in | input | 256 | Source lane; bits 127:0 are the cipher state |
| round_key | input | 128 | Round key XORed into the result |
| lane_out | output | 256 | Registered destination lane |
| valid_out | output | 1 | Pulses one cycle after each start |

## Verification
The bench checks the standard worked example for a middle round and for the closing round. These catch a reversed byte order, a swapped step order, and a closing round that still mixes columns. An all-zero state shows the inverse-of-zero case in the substitution box, which a design that mishandles zero would turn into a wrong constant in every byte. Random upper lane bits and idle cycles with changing inputs expose a design that corrupts the upper half or lets the register follow its inputs without a start. Back-to-back starts with alternating round kinds and a reset asserted together with `start` show whether stale or wrongly gated results are held.

// File: rtl/aes_rnd_pkg.sv
package aes_rnd_pkg;

    localparam int BYTE_W      = 8;
    localparam int STATE_BYTES = 16;
    localparam int ROWS        = 4;
    localparam int COLS        = STATE_BYTES / ROWS;
    localparam int STATE_W     = STATE_BYTES * BYTE_W;
    localparam logic [7:0] AFFINE_C = 8'h63;
    localparam logic [7:0] REDUCE   = 8'h1B;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef byte_t [STATE_BYTES-1:0] state_t;   // element i at bits 8i+7:8i

    typedef enum logic {
        RND_MIXED = 1'b0,
        RND_FINAL = 1'b1
    } rnd_kind_e;

    typedef struct packed {
        logic      go;
        rnd_kind_e kind;
    } rnd_req_t;

    // multiply by x modulo x^8+x^4+x^3+x+1
    function automatic byte_t gf_xtime(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? REDUCE : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc;
        byte_t sh;
        acc = '0;
        sh  = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // a^254 is the inverse for a != 0 and gives 0 for a == 0
    function automatic byte_t gf_inv(input byte_t a);
        byte_t r;
        byte_t p;
        logic [7:0] e;
        e = 8'd254;
        r = 8'h01;
        p = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (e[i]) r = gf_mul(r, p);
            p = gf_mul(p, p);
        end
        return r;
    endfunction

    function automatic byte_t rotl8(input byte_t v, input int n);
        return byte_t'((v << n) | (v >> (BYTE_W - n)));
    endfunction

    function automatic byte_t sbox_fwd(input byte_t a);
        byte_t inv;
        inv = gf_inv(a);
        return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3)
                   ^ rotl8(inv, 4) ^ AFFINE_C;
    endfunction

endpackage

// File: rtl/aes_shift_rows.sv
module aes_shift_rows
    import aes_rnd_pkg::*;
(
    input  state_t st_in,
    output state_t st_out
);
    // row r of column c takes row r of column (c + r) mod COLS
    for (genvar c = 0; c < COLS; c++) begin : g_col
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            localparam int SRC_COL = (c + r) % COLS;
            assign st_out[r + ROWS*c] = st_in[r + ROWS*SRC_COL];
        end
    end
endmodule

// File: rtl/aes_sub_bytes.sv
module aes_sub_bytes
    import aes_rnd_pkg::*;
#(
    parameter int N_BYTES = STATE_BYTES
)(
    input  byte_t [N_BYTES-1:0] b_in,
    output byte_t [N_BYTES-1:0] b_out
);
    for (genvar i = 0; i < N_BYTES; i++) begin : g_sbox
        assign b_out[i] = sbox_fwd(b_in[i]);
    end
endmodule

// File: rtl/aes_mix_columns.sv
module aes_mix_columns
    import aes_rnd_pkg::*;
#(
    parameter int N_COLS = COLS
)(
    input  byte_t [ROWS*N_COLS-1:0] st_in,
    output byte_t [ROWS*N_COLS-1:0] st_out
);
    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            localparam int B0 = ROWS*c + r;
            localparam int B1 = ROWS*c + (r + 1) % ROWS;
            localparam int B2 = ROWS*c + (r + 2) % ROWS;
            localparam int B3 = ROWS*c + (r + 3) % ROWS;
            byte_t dbl0, dbl1;
            assign dbl0 = gf_xtime(st_in[B0]);
            assign dbl1 = gf_xtime(st_in[B1]);
            // 02*a0 ^ 03*a1 ^ a2 ^ a3
            assign st_out[B0] = dbl0 ^ dbl1 ^ st_in[B1] ^ st_in[B2] ^ st_in[B3];
        end
    end
endmodule

// File: rtl/aes_round_lane.sv
module aes_round_lane
    import aes_rnd_pkg::*;
#(
    parameter int LANE_WIDTH = 256
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  last_round,
    input  logic [LANE_WIDTH-1:0] lane_in,
    input  logic [STATE_W-1:0]    round_key,
    output logic [LANE_WIDTH-1:0] lane_out,
    output logic                  valid_out
);
    localparam int UPPER_W = LANE_WIDTH - STATE_W;

    rnd_req_t req;
    state_t   st_src, st_shift, st_sub, st_mix, st_pre, st_res;

    assign req.go   = start;
    assign req.kind = last_round ? RND_FINAL : RND_MIXED;
    assign st_src   = state_t'(lane_in[STATE_W-1:0]);

    aes_shift_rows u_shift (
        .st_in  (st_src),
        .st_out (st_shift)
    );

    aes_sub_bytes #(.N_BYTES(STATE_BYTES)) u_sub (
        .b_in  (st_shift),
        .b_out (st_sub)
    );

    aes_mix_columns #(.N_COLS(COLS)) u_mix (
        .st_in  (st_sub),
        .st_out (st_mix)
    );

    always_comb begin
        unique case (req.kind)
            RND_FINAL: st_pre = st_sub;
            default:   st_pre = st_mix;
        endcase
        st_res = state_t'(st_pre ^ round_key);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lane_out  <= '0;
            valid_out <= 1'b0;
        end else begin
            valid_out <= req.go;
            if (req.go) begin
                lane_out <= {lane_in[LANE_WIDTH-1 -: UPPER_W], st_res};
            end
        end
    end
endmodule

// File: rtl/aes_round_chk.sv
module aes_round_chk #(
    parameter int LANE_WIDTH = 256
)(
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic [LANE_WIDTH-1:0] lane_in,
    input logic [LANE_WIDTH-1:0] lane_out,
    input logic                  valid_out
);
    a_r4_valid_after_start: assert property (@(posedge clk) disable iff (rst)
        start |=> valid_out);

    a_r4_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
        !start |=> !valid_out);

    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(lane_out));

    a_r3_upper_passthrough: assert property (@(posedge clk) disable iff (rst)
        start |=> lane_out[LANE_WIDTH-1:128] == $past(lane_in[LANE_WIDTH-1:128]));

    a_r6_reset_clears: assert property (@(posedge clk)
        rst |=> (!valid_out && lane_out == '0));
endmodule

bind aes_round_lane aes_round_chk #(.LANE_WIDTH(LANE_WIDTH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .lane_in   (lane_in),
    .lane_out  (lane_out),
    .valid_out (valid_out)
);

// File: tb/tb_aes_round_lane.sv
`timescale 1ns/1ps
module tb_aes_round_lane;

    logic         clk = 1'b0;
    logic         rst;
    logic         start;
    logic         last_round;
    logic [255:0] lane_in;
    logic [127:0] round_key;
    logic [255:0] lane_out;
    logic         valid_out;

    int compared   = 0;
    int mismatched = 0;
    bit done       = 0;

    logic [255:0] exp_lane;
    logic         exp_valid;
    int           sb [256];

    always #2.5 clk = ~clk;

    aes_round_lane dut (
        .clk(clk), .rst(rst), .start(start), .last_round(last_round),
        .lane_in(lane_in), .round_key(round_key),
        .lane_out(lane_out), .valid_out(valid_out)
    );

    // substitution table built by walking generator 3 and its inverse
    function automatic int rl(int v, int n);
        return ((v << n) | (v >> (8 - n))) & 8'hFF;
    endfunction

    task automatic build_sbox();
        int p = 1, q = 1, x;
        do begin
            p = (p ^ (p << 1) ^ (((p & 8'h80) != 0) ? 8'h1B : 0)) & 8'hFF;
            q = (q ^ (q << 1)) & 8'hFF;
            q = (q ^ (q << 2)) & 8'hFF;
            q = (q ^ (q << 4)) & 8'hFF;
            if ((q & 8'h80) != 0) q = q ^ 8'h09;
            x = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4);
            sb[p] = (x ^ 8'h63) & 8'hFF;
        end while (p != 1);
        sb[0] = 8'h63;
    endtask

    function automatic int gm(int a, int b);
        int acc = 0;
        int aa = a;
        for (int i = 0; i < 8; i++) begin
            if (((b >> i) & 1) != 0) acc = acc ^ aa;
            aa = aa << 1;
            if ((aa & 16'h100) != 0) aa = aa ^ 16'h11B;
        end
        return acc & 8'hFF;
    endfunction

    function automatic logic [127:0] model(logic [127:0] s, logic [127:0] k, logic fin);
        int a [16];
        int b [16];
        logic [127:0] o;
        for (int i = 0; i < 16; i++) a[i] = int'(s[8*i +: 8]);
        for (int c = 0; c < 4; c++)
            for (int r = 0; r < 4; r++)
                b[r + 4*c] = sb[a[r + 4*((c + r) % 4)]];
        if (!fin) begin
            for (int c = 0; c < 4; c++)
                for (int r = 0; r < 4; r++)
                    a[r + 4*c] = gm(2, b[4*c + r]) ^ gm(3, b[4*c + (r+1)%4])
                               ^ b[4*c + (r+2)%4] ^ b[4*c + (r+3)%4];
        end else begin
            for (int i = 0; i < 16; i++) a[i] = b[i];
        end
        for (int i = 0; i < 16; i++) o[8*i +: 8] = 8'(a[i]) ^ k[8*i +: 8];
        return o;
    endfunction

    // written order of a hex string puts byte 0 first
    function automatic logic [127:0] rev16(logic [127:0] x);
        logic [127:0] y;
        for (int i = 0; i < 16; i++) y[8*i +: 8] = x[8*(15-i) +: 8];
        return y;
    endfunction

    function automatic logic [255:0] rnd256();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [127:0] rnd128();
        logic [127:0] v;
        for (int i = 0; i < 4; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    task automatic check(string tag, logic ok, logic [255:0] act, logic [255:0] expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // drive one cycle of inputs, advance, then compare against the model
    task automatic tick(logic r, logic s, logic fin, logic [255:0] ln,
                        logic [127:0] k, string tag);
        rst = r; start = s; last_round = fin; lane_in = ln; round_key = k;
        if (r) begin
            exp_lane = '0; exp_valid = 1'b0;
        end else begin
            exp_valid = s;
            if (s) exp_lane = {ln[255:128], model(ln[127:0], k, fin)};
        end
        @(negedge clk);
        check({tag, " valid"}, valid_out === exp_valid,
              {255'b0, valid_out}, {255'b0, exp_valid});
        check({tag, " lane"}, lane_out === exp_lane, lane_out, exp_lane);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [255:0] up;
        build_sbox();
        rst = 1'b1; start = 1'b0; last_round = 1'b0; lane_in = '0; round_key = '0;
        @(negedge clk);

        // R6: reset state
        for (int i = 0; i < 3; i++) tick(1, 0, 0, rnd256(), rnd128(), "R6 reset");
        // R5: idle cycles with changing inputs keep zero
        for (int i = 0; i < 3; i++) tick(0, 0, i[0], rnd256(), rnd128(), "R5 idle");

        // R1 and R3: worked middle-round example, random upper half
        up = rnd256();
        tick(0, 1, 0, {up[255:128], rev16(128'h193de3bea0f4e22b9ac68d2ae9f84808)},
             rev16(128'ha0fafe1788542cb123a339392a6c7605), "R1 mid round");
        check("R1 known vector", lane_out[127:0] === rev16(128'ha49c7ff2689f352b6b5bea43026a5049),
              {128'b0, lane_out[127:0]}, {128'b0, rev16(128'ha49c7ff2689f352b6b5bea43026a5049)});
        check("R3 upper lane", lane_out[255:128] === up[255:128],
              {lane_out[255:128], 128'b0}, {up[255:128], 128'b0});

        // R4/R5: result held, valid drops
        tick(0, 0, 1, rnd256(), rnd128(), "R4 R5 hold");

        // R2: closing-round example
        tick(0, 1, 1, {128'h0, rev16(128'heb40f21e592e38848ba113e71bc342d2)},
             rev16(128'hd014f9a8c9ee2589e13f0cc8b6630ca6), "R2 final round");
        check("R2 known vector", lane_out[127:0] === rev16(128'h3925841d02dc09fbdc118597196a0b32),
              {128'b0, lane_out[127:0]}, {128'b0, rev16(128'h3925841d02dc09fbdc118597196a0b32)});

        // R7: zero bytes substitute to 0x63, both round kinds
        tick(0, 1, 1, {128'hFFFF, 128'h0}, '0, "R7 zero final");
        check("R7 zero byte", lane_out[127:0] === {16{8'h63}},
              {128'b0, lane_out[127:0]}, {128'b0, {16{8'h63}}});
        tick(0, 1, 0, '0, '0, "R7 zero mixed");
        check("R7 zero mixed", lane_out[127:0] === {16{8'h63}},
              {128'b0, lane_out[127:0]}, {128'b0, {16{8'h63}}});

        // R8: back-to-back starts with alternating kinds
        for (int i = 0; i < 40; i++)
            tick(0, 1, (i % 3) == 0, rnd256(), rnd128(), "R8 back-to-back");

        // R1 R2 R4 R5: random start pattern
        for (int i = 0; i < 300; i++)
            tick(0, ($urandom % 3) == 0, $urandom % 2, rnd256(), rnd128(), "R4 R5 random");

        // R6: reset wins over a start
        tick(1, 1, 0, rnd256(), rnd128(), "R6 reset with start");
        tick(0, 0, 0, rnd256(), rnd128(), "R6 after reset");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule